// File: doc/BRIEF.md
# Region-Gated Completion Interrupt Controller

This block collects transfer-completion reports from a multi-channel DMA engine and turns them into interrupts. Each report carries a 6-bit completion code and two enable flags. When either flag is set, the block sets the pending bit whose index equals the code, in a 64-bit pending register. A 64-bit enable register qualifies the pending bits. The OR of all qualified bits drives a global interrupt line.

The block has one interrupt line per shadow region. Each region owns a 64-bit access mask that works as a second enable for that region's line. Masks may overlap, so one completion can raise several region lines at once. Software reaches the block over a 32-bit word bus. Each 64-bit register appears as a low word and a high word. Set and clear actions go through dedicated write-1 registers. Each region also has a shadow view, in which writes and reads are confined to the bits in that region's mask.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: A report with `cmpl_valid_i` high sets a pending bit only if `cmpl_final_en_i` or `cmpl_inter_en_i` is high. With both flags low, the pending register is left unchanged.
- R2: The pending bit index equals the code. Codes 0..31 land in the low word and codes 32..63 in the high word at bit code-32, so code 63 reads as 0x8000_0000 in the high pending word. Byte address = view<<8 | word<<2. Words: 0/1 pending lo/hi (read), 2/3 pending clear lo/hi, 4/5 enable lo/hi (read), 6/7 enable set lo/hi, 8/9 enable clear lo/hi, 16+2r/17+2r region r mask lo/hi.
- R3: `glb_irq_o` is high in the cycle after the pending and enable registers hold a common set bit. It is low in the cycle after they hold none.
- R4: `rgn_irq_o[r]` is high one cycle after some bit is set in pending, in enable and in region r's mask at the same time.
- R5: If two region masks share a bit, one completion with that code raises both region lines.
- R6: Pending bits stay set until a 1 is written to the matching bit of the pending clear word. Writing 0 there has no effect.
- R7: Enable bits change only through the set words (1 sets) and the clear words (1 clears). Writes of 0, and writes to the enable read words, have no effect.
- R8: View 0 is the global view and views 1..N are the shadow views of regions 0..N-1. In a shadow view, clear and set writes touch only bits in that region's mask, and pending and enable reads show zero outside it. Views above N read as zero and ignore writes.
- R9: If a completion sets a pending bit in the same cycle that software clears that bit, the bit ends up set.
- R10: Reset clears the pending, enable and mask registers and drives all interrupt lines low.
- R11: Region masks are read and written directly only in the global view. Through a shadow view a mask word ignores writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmpl_valid_i | input | 1 | Completion report strobe |
| cmpl_code_i | input | 6 | Completion code (pending bit index) |
| cmpl_final_en_i | input | 1 | Final-completion interrupt enable flag |
| cmpl_inter_en_i | input | 1 | Intermediate-completion interrupt enable flag |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | ADDR_W | Byte address: view in [11:8], word in [7:2] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| glb_irq_o | output | 1 | Global completion interrupt |
| rgn_irq_o | output | NUM_REGIONS | Per-region completion interrupts |

## Verification
The hardware set of a pending bit and the software clear of the same bit can land in one cycle. The bench provokes this on purpose: it drives a completion for a code while it writes 1 to that bit's clear word. It judges the result by reading the pending word back and by watching the interrupt lines, expecting the set to win. The random phase issues completions and bus writes of every kind, from every view, in the same cycles. A cycle-level reference model then predicts the pending, enable and mask state and every interrupt line.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int CODE_W   = 6;
  localparam int VEC_W    = 1 << CODE_W;
  localparam int HALF_W   = 32;
  localparam int WORD_LSB = 2;
  localparam int WORD_W   = 6;
  localparam int VIEW_LSB = WORD_LSB + WORD_W;

  // register pair index = word >> 1
  localparam logic [4:0] P_PEND = 5'd0;
  localparam logic [4:0] P_PCLR = 5'd1;
  localparam logic [4:0] P_IEN  = 5'd2;
  localparam logic [4:0] P_ISET = 5'd3;
  localparam logic [4:0] P_ICLR = 5'd4;
  localparam logic [4:0] P_MASK = 5'd8;

  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/cic_pending.sv
module cic_pending
  import cic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_valid_i,
  input  logic [CODE_W-1:0] cmpl_code_i,
  input  logic              cmpl_final_en_i,
  input  logic              cmpl_inter_en_i,
  input  vec_t              clr_i,
  output vec_t              pend_o
);
  vec_t hw_set;
  vec_t pend_q;

  always_comb begin
    hw_set = '0;
    if (cmpl_valid_i && (cmpl_final_en_i || cmpl_inter_en_i))
      hw_set[cmpl_code_i] = 1'b1;
  end

  // set has priority over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | hw_set;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cic_regfile.sv
module cic_regfile
  import cic_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_req_i,
  input  logic                         bus_we_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [HALF_W-1:0]            bus_wdata_i,
  output logic [HALF_W-1:0]            bus_rdata_o,
  input  vec_t                         pend_i,
  output vec_t                         pend_clr_o,
  output vec_t                         ien_o,
  output logic [NUM_REGIONS-1:0][VEC_W-1:0] amask_o
);
  localparam int VIEW_W = ADDR_W - VIEW_LSB;

  logic [VIEW_W-1:0] view;
  logic [WORD_W-1:0] word;
  logic [4:0]        pair;
  logic              hi_half;
  logic              view_ok;
  logic              is_glb;
  vec_t              view_msk;
  vec_t              wd64;
  vec_t              eff;
  logic              wr;
  vec_t              ien_q;
  vec_t              iset;
  vec_t              iclr;
  vec_t              rd64;
  logic [NUM_REGIONS-1:0][VEC_W-1:0] amask_q;
  logic [NUM_REGIONS-1:0]            mask_we;
  logic [NUM_REGIONS-1:0]            mask_rd;

  assign view    = bus_addr_i[VIEW_LSB +: VIEW_W];
  assign word    = bus_addr_i[WORD_LSB +: WORD_W];
  assign pair    = word[WORD_W-1:1];
  assign hi_half = word[0];
  assign is_glb  = (view == '0);

  always_comb begin
    view_ok  = is_glb;
    view_msk = is_glb ? '1 : '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (view == VIEW_W'(r + 1)) begin
        view_ok  = 1'b1;
        view_msk = amask_q[r];
      end
    end
  end

  assign wd64 = hi_half ? {bus_wdata_i, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, bus_wdata_i};
  assign eff  = wd64 & view_msk;
  assign wr   = bus_req_i && bus_we_i && view_ok;

  assign pend_clr_o = (wr && pair == P_PCLR) ? eff : '0;
  assign iset       = (wr && pair == P_ISET) ? eff : '0;
  assign iclr       = (wr && pair == P_ICLR) ? eff : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ien_q <= '0;
    else         ien_q <= (ien_q | iset) & ~iclr;
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_mask
    assign mask_rd[r] = is_glb && (pair == 5'(P_MASK + r));
    assign mask_we[r] = bus_req_i && bus_we_i && mask_rd[r];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        amask_q[r] <= '0;
      end else if (mask_we[r]) begin
        if (hi_half) amask_q[r][VEC_W-1:HALF_W] <= bus_wdata_i;
        else         amask_q[r][HALF_W-1:0]     <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    rd64 = '0;
    if (pair == P_PEND)     rd64 = pend_i & view_msk;
    else if (pair == P_IEN) rd64 = ien_q & view_msk;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (mask_rd[r]) rd64 = amask_q[r];
  end

  assign bus_rdata_o = !view_ok ? '0 :
                       hi_half ? rd64[VEC_W-1:HALF_W] : rd64[HALF_W-1:0];
  assign ien_o       = ien_q;
  assign amask_o     = amask_q;
endmodule

// File: rtl/cic_irq_gen.sv
module cic_irq_gen
  import cic_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  vec_t                              pend_i,
  input  vec_t                              ien_i,
  input  logic [NUM_REGIONS-1:0][VEC_W-1:0] amask_i,
  output logic                              glb_irq_o,
  output logic [NUM_REGIONS-1:0]            rgn_irq_o
);
  vec_t                   qual;
  logic [NUM_REGIONS-1:0] rgn_d;

  assign qual = pend_i & ien_i;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    assign rgn_d[r] = |(qual & amask_i[r]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_irq_o <= 1'b0;
      rgn_irq_o <= '0;
    end else begin
      glb_irq_o <= |qual;
      rgn_irq_o <= rgn_d;
    end
  end
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmpl_valid_i,
  input  logic [5:0]             cmpl_code_i,
  input  logic                   cmpl_final_en_i,
  input  logic                   cmpl_inter_en_i,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  output logic                   glb_irq_o,
  output logic [NUM_REGIONS-1:0] rgn_irq_o
);
  vec_t pend_w;
  vec_t pclr_w;
  vec_t ien_w;
  logic [NUM_REGIONS-1:0][VEC_W-1:0] amask_w;

  cic_pending u_pending (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmpl_valid_i    (cmpl_valid_i),
    .cmpl_code_i     (cmpl_code_i),
    .cmpl_final_en_i (cmpl_final_en_i),
    .cmpl_inter_en_i (cmpl_inter_en_i),
    .clr_i           (pclr_w),
    .pend_o          (pend_w)
  );

  cic_regfile #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
  ) u_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend_w),
    .pend_clr_o  (pclr_w),
    .ien_o       (ien_w),
    .amask_o     (amask_w)
  );

  cic_irq_gen #(
    .NUM_REGIONS (NUM_REGIONS)
  ) u_irq_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_w),
    .ien_i     (ien_w),
    .amask_i   (amask_w),
    .glb_irq_o (glb_irq_o),
    .rgn_irq_o (rgn_irq_o)
  );
endmodule

// File: rtl/cmpl_irq_ctrl_chk.sv
module cmpl_irq_ctrl_chk
  import cic_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              cmpl_valid_i,
  input logic [5:0]                        cmpl_code_i,
  input logic                              cmpl_final_en_i,
  input logic                              cmpl_inter_en_i,
  input logic                              bus_req_i,
  input logic                              bus_we_i,
  input vec_t                              pend,
  input vec_t                              ien,
  input logic [NUM_REGIONS-1:0][VEC_W-1:0] amask,
  input logic                              glb_irq_o,
  input logic [NUM_REGIONS-1:0]            rgn_irq_o
);
  // R1, R9: a flagged report leaves its bit set next cycle, whatever the bus does
  a_r1_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && (cmpl_final_en_i || cmpl_inter_en_i) |=> pend[$past(cmpl_code_i)]);

  a_r1_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && !cmpl_final_en_i && !cmpl_inter_en_i && !pend[cmpl_code_i]
    |=> !pend[$past(cmpl_code_i)]);

  a_r3_glb_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(glb_irq_o) |-> $past((pend & ien) != '0));

  a_r6_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i) |=> ((~pend & $past(pend)) == '0));

  a_r7_ien_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i) |=> $stable(ien));

  a_r11_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i) |=> $stable(amask));

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    a_r4_rgn_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rgn_irq_o[r]) |-> $past((pend & ien & amask[r]) != '0));
    a_r4_rgn_sub_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rgn_irq_o[r] |-> glb_irq_o);
  end
endmodule

bind cmpl_irq_ctrl cmpl_irq_ctrl_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmpl_valid_i    (cmpl_valid_i),
  .cmpl_code_i     (cmpl_code_i),
  .cmpl_final_en_i (cmpl_final_en_i),
  .cmpl_inter_en_i (cmpl_inter_en_i),
  .bus_req_i       (bus_req_i),
  .bus_we_i        (bus_we_i),
  .pend            (pend_w),
  .ien             (ien_w),
  .amask           (amask_w),
  .glb_irq_o       (glb_irq_o),
  .rgn_irq_o       (rgn_irq_o)
);

// File: tb/cmpl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module cmpl_irq_ctrl_bench;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          c_valid = 1'b0;
  logic [5:0]    c_code = '0;
  logic          c_fin = 1'b0;
  logic          c_int = 1'b0;
  logic          b_req = 1'b0;
  logic          b_we = 1'b0;
  logic [11:0]   b_addr = '0;
  logic [31:0]   b_wdata = '0;
  logic [31:0]   b_rdata;
  logic          glb_irq;
  logic [NR-1:0] rgn_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0]   m_pend = '0;
  logic [63:0]   m_ien = '0;
  logic [63:0]   m_mask [NR];
  logic [31:0]   last_rd;

  always #2.5 clk = ~clk;

  cmpl_irq_ctrl #(.NUM_REGIONS(NR), .ADDR_W(12)) u_cmpl_irq_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .cmpl_valid_i (c_valid), .cmpl_code_i (c_code),
    .cmpl_final_en_i (c_fin), .cmpl_inter_en_i (c_int),
    .bus_req_i (b_req), .bus_we_i (b_we), .bus_addr_i (b_addr),
    .bus_wdata_i (b_wdata), .bus_rdata_o (b_rdata),
    .glb_irq_o (glb_irq), .rgn_irq_o (rgn_irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ad(int view, int word);
    return {view[3:0], word[5:0], 2'b00};
  endfunction

  function automatic logic [63:0] view_mask(int v);
    if (v == 0) return '1;
    if (v <= NR) return m_mask[v-1];
    return '0;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    int v = int'(a[11:8]);
    int w = int'(a[7:2]);
    logic [63:0] msk = view_mask(v);
    logic [63:0] s = '0;
    if ((w >> 1) == 0) s = m_pend & msk;
    else if ((w >> 1) == 2) s = m_ien & msk;
    else if (v == 0 && w >= 16 && w < 16 + 2 * NR) s = m_mask[(w - 16) / 2];
    return w[0] ? s[63:32] : s[31:0];
  endfunction

  // one clock: drive, check read, predict, advance, check irq lines
  task automatic cycle(logic v, logic [5:0] code, logic fin, logic intr,
                       logic we, logic [11:0] addr, logic [31:0] wd, string tag);
    int vw;
    int w;
    logic [63:0] d64;
    logic [63:0] clr = '0;
    logic [63:0] iset = '0;
    logic [63:0] iclr = '0;
    logic [63:0] hw = '0;
    logic exp_g;
    logic [NR-1:0] exp_r;
    logic [63:0] nmask [NR];
    c_valid = v; c_code = code; c_fin = fin; c_int = intr;
    b_req = we; b_we = we; b_addr = addr; b_wdata = wd;
    #1;
    if (!we) begin
      last_rd = b_rdata;
      chk({tag, " read"}, b_rdata, model_read(addr));
    end
    vw = int'(addr[11:8]);
    w = int'(addr[7:2]);
    for (int r = 0; r < NR; r++) nmask[r] = m_mask[r];
    if (we && vw <= NR) begin
      d64 = w[0] ? {wd, 32'h0} : {32'h0, wd};
      d64 &= view_mask(vw);
      case (w >> 1)
        1: clr = d64;
        3: iset = d64;
        4: iclr = d64;
        default:
          if (vw == 0 && w >= 16 && w < 16 + 2 * NR) begin
            if (w[0]) nmask[(w - 16) / 2][63:32] = wd;
            else      nmask[(w - 16) / 2][31:0]  = wd;
          end
      endcase
    end
    if (v && (fin || intr)) hw[code] = 1'b1;
    exp_g = |(m_pend & m_ien);
    for (int r = 0; r < NR; r++) exp_r[r] = |(m_pend & m_ien & m_mask[r]);
    m_pend = (m_pend & ~clr) | hw;
    m_ien = (m_ien | iset) & ~iclr;
    for (int r = 0; r < NR; r++) m_mask[r] = nmask[r];
    @(posedge clk);
    @(negedge clk);
    chk("R3 glb_irq", glb_irq, exp_g);
    chk("R4 rgn_irq", rgn_irq, exp_r);
  endtask

  task automatic wr(int view, int word, logic [31:0] d, string tag);
    cycle(1'b0, 6'd0, 1'b0, 1'b0, 1'b1, ad(view, word), d, tag);
  endtask

  task automatic rd(int view, int word, string tag);
    cycle(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, ad(view, word), 32'h0, tag);
  endtask

  task automatic cmpl(logic [5:0] code, logic fin, logic intr, string tag);
    cycle(1'b1, code, fin, intr, 1'b0, ad(0, 0), 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) m_mask[r] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 glb_irq in reset", glb_irq, 1'b0);
    chk("R10 rgn_irq in reset", rgn_irq, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 0, "R10"); chk("R10 pend lo", last_rd, 32'h0);
    rd(0, 5, "R10"); chk("R10 ien hi", last_rd, 32'h0);
    rd(0, 17, "R10"); chk("R10 mask hi", last_rd, 32'h0);

    wr(0, 6, 32'hFFFF_FFFF, "R7");
    wr(0, 7, 32'hFFFF_FFFF, "R7");

    cmpl(6'd5, 1'b0, 1'b0, "R1");
    rd(0, 0, "R1"); chk("R1 no flag", last_rd, 32'h0);
    chk("R3 stays low", glb_irq, 1'b0);
    cmpl(6'd5, 1'b0, 1'b1, "R1");
    rd(0, 0, "R1"); chk("R1 inter flag", last_rd, 32'h20);
    chk("R3 irq up", glb_irq, 1'b1);

    cmpl(6'd63, 1'b1, 1'b0, "R2");
    rd(0, 1, "R2"); chk("R2 code 63 hi", last_rd, 32'h8000_0000);
    rd(0, 0, "R2"); chk("R2 lo untouched", last_rd, 32'h20);

    wr(0, 2, 32'h0, "R6");
    rd(0, 0, "R6"); chk("R6 zero write", last_rd, 32'h20);
    wr(0, 2, 32'h20, "R6");
    wr(0, 3, 32'h8000_0000, "R6");
    rd(0, 1, "R6"); chk("R6 cleared hi", last_rd, 32'h0);
    rd(0, 0, "R6"); chk("R3 irq down", glb_irq, 1'b0);

    wr(0, 4, 32'h0, "R7");
    wr(0, 8, 32'h0, "R7");
    rd(0, 4, "R7"); chk("R7 zero writes", last_rd, 32'hFFFF_FFFF);
    wr(0, 8, 32'hFFFF_0000, "R7");
    rd(0, 4, "R7"); chk("R7 clear word", last_rd, 32'h0000_FFFF);

    wr(0, 16, 32'h1, "R11");
    wr(0, 18, 32'h3, "R11");
    wr(0, 20, 32'h2, "R11");
    cmpl(6'd0, 1'b1, 1'b0, "R5");
    rd(0, 0, "R5"); chk("R5 overlap", rgn_irq, 4'b0011);
    cmpl(6'd1, 1'b1, 1'b0, "R4");
    rd(0, 0, "R4"); chk("R4 three regions", rgn_irq, 4'b0111);
    wr(0, 8, 32'h2, "R4");
    rd(0, 0, "R4"); chk("R4 enable gates", rgn_irq, 4'b0011);

    wr(1, 2, 32'h3, "R8");
    rd(0, 0, "R8"); chk("R8 shadow clear masked", last_rd, 32'h2);
    rd(3, 0, "R8"); chk("R8 shadow read in mask", last_rd, 32'h2);
    rd(1, 0, "R8"); chk("R8 shadow read out of mask", last_rd, 32'h0);
    wr(1, 8, 32'hFFFF_FFFF, "R8");
    rd(0, 4, "R8"); chk("R8 shadow enable clear", last_rd, 32'h0000_FFFC);
    wr(6, 6, 32'hFFFF_FFFF, "R8");
    rd(6, 4, "R8"); chk("R8 bad view", last_rd, 32'h0);

    wr(1, 16, 32'hFFFF_FFFF, "R11");
    rd(0, 16, "R11"); chk("R11 shadow mask write", last_rd, 32'h1);
    rd(1, 16, "R11"); chk("R11 shadow mask read", last_rd, 32'h0);

    cycle(1'b1, 6'd1, 1'b1, 1'b0, 1'b1, ad(0, 2), 32'h2, "R9");
    cycle(1'b1, 6'd7, 1'b0, 1'b1, 1'b1, ad(0, 2), 32'h80, "R9");
    rd(0, 0, "R9"); chk("R9 set wins", last_rd, 32'h82);

    for (int i = 0; i < 4000; i++) begin
      logic we = ($urandom % 2) == 1;
      int view = int'($urandom % (NR + 2));
      int word = (($urandom % 4) == 0) ? int'($urandom % 64)
               : (($urandom % 2) == 0) ? int'($urandom % 10)
               : 16 + int'($urandom % (2 * NR));
      logic [31:0] d = $urandom;
      if (($urandom % 4) == 0) d = d & $urandom;
      cycle(($urandom % 2) == 1, 6'($urandom), ($urandom % 2) == 1,
            ($urandom % 3) == 0, we, ad(view, word), d, "R2 R8 R9 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule